// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block is a serial master for one peripheral that shares a single data wire for both directions. The wire works as a wired-AND: the master and the peripheral can each only pull it low, and a pull-up holds it high otherwise. The master has no output for "drive high". It has only a pull-low enable, so a one bit is sent by releasing the wire. The external interface returns the wire level inverted on the sense input. The block undoes that inversion before it stores a received bit.

A host loads a command word, the command length, the response length and a clock divisor. It then pulses `start`. The block drops chip select and shifts out the command, most significant bit first. It then releases the wire and clocks in the response. At the end it raises chip select and pulses `done`. All clocking is mode 0: the serial clock idles low, the master changes data while the clock is low, and bits are sampled on the rising edge.

A set of supply-enable outputs powers the peripheral and stays high for as long as the block is enabled.

Top module: `tw_spi_master`

## Requirements
- R1: After reset and whenever no transaction is in progress: `cs_n`=1, `sclk`=0, `sdo_pull`=0 (wire released) and `done`=0.
- R2: The serial clock idles low. `sdo_pull` changes only while `sclk` is low. Each received bit is sampled in the cycle `sclk` rises.
- R3: The command phase sends `tx_len_m1`+1 bits (1 to 32), taken from the low end of `tx_data`, most significant of those bits first. A 0 bit is sent with `sdo_pull`=1 and a 1 bit with `sdo_pull`=0.
- R4: After the falling clock edge that ends the last command bit, `sdo_pull` stays 0 for the rest of the transaction. The response phase is `rx_len_m1`+1 bits long (1 to 32).
- R5: Each received bit equals the inverse of `sdi_n` at the rising edge. `rx_data` holds the response right-aligned, first-received bit most significant, with all unused upper bits 0.
- R6: One transaction is one continuous low period of `cs_n`, containing exactly (`tx_len_m1`+1)+(`rx_len_m1`+1) rising clock edges.
- R7: Each high and each low half-period of `sclk` lasts `div_m1`+1 system clocks. `cs_n` is low for `div_m1`+1 clocks before the first rising edge. `cs_n` stays low for `div_m1`+1 clocks after the last falling edge.
- R8: `done` is high for exactly one clock: the first clock in which `cs_n` is high again. `rx_data` is valid from that clock and holds its value until the next accepted start.
- R9: `start` is ignored while a transaction is in progress (`cs_n` low) and while `enable` is 0.
- R10: Every bit of `pwr_en` equals `enable`.
- R11: A `start` presented in the same clock as `done` is accepted, and the next transaction follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; gates start and drives supply enables |
| start | input | 1 | One-clock request to begin a transaction |
| tx_data | input | 32 | Command word, right-aligned |
| tx_len_m1 | input | 5 | Command bit count minus one |
| rx_len_m1 | input | 5 | Response bit count minus one |
| div_m1 | input | 8 | Half-period of the serial clock in system clocks, minus one |
| rx_data | output | 32 | Received response, right-aligned |
| done | output | 1 | One-clock completion pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| sdo_pull | output | 1 | When 1, pull the shared data wire low |
| sdi_n | input | 1 | Inverted level of the shared data wire |
| pwr_en | output | 4 | Peripheral supply enables |

## Verification
The case where two functions share one clock is the `done` pulse of one transaction coinciding with the `start` of the next. The bench raises `start` in the very clock where it first sees `done`. It judges the result on three points. The first response must already be complete in `rx_data` at that moment. A second chip-select period must follow, with its own command and response delivered correctly. Between the two, `cs_n` must be high for only that one clock.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;

  typedef enum logic [2:0] {
    TWS_IDLE  = 3'd0,
    TWS_SETUP = 3'd1,
    TWS_HIGH  = 3'd2,
    TWS_LOW   = 3'd3,
    TWS_HOLD  = 3'd4
  } tws_state_e;

endpackage

// File: rtl/tw_spi_divider.sv
module tw_spi_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == div_q);

  always_comb begin
    div_d = div_q;
    if (load) begin
      div_d = div_in;
    end
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) begin
        div_q <= div_d;
      end
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tw_spi_shifter.sv
module tw_spi_shifter #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_out,
  input  logic              sample_in,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len_m1,
  input  logic              sdi_n,
  output logic              tx_msb,
  output logic [DATA_W-1:0] rx_word
);

  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              tx_en, rx_en;

  assign tx_en = load | shift_out;
  assign rx_en = load | sample_in;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      // left-align the command so its first bit sits at the top
      tx_d = tx_data << (TOP_IDX - tx_len_m1);
      rx_d = '0;
    end else begin
      if (shift_out) begin
        tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
      if (sample_in) begin
        // the sense path arrives inverted
        rx_d = {rx_q[DATA_W-2:0], ~sdi_n};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_en) begin
      tx_q <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_en) begin
      rx_q <= rx_d;
    end
  end

  assign tx_msb  = tx_q[DATA_W-1];
  assign rx_word = rx_q;

endmodule

// File: rtl/tw_spi_ctrl.sv
module tw_spi_ctrl
  import tw_spi_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len_m1,
  input  logic [LEN_W-1:0] rx_len_m1,
  input  logic             tick,
  output logic             load,
  output logic             shift_out,
  output logic             sample_in,
  output logic             busy,
  output logic             drive_en,
  output logic             cs_n,
  output logic             sclk,
  output logic             done
);

  tws_state_e       state_q, state_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] rxlen_q, rxlen_d;
  logic             rd_q, rd_d;
  logic             done_q, done_d;

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    rxlen_d   = rxlen_q;
    rd_d      = rd_q;
    done_d    = 1'b0;
    load      = 1'b0;
    shift_out = 1'b0;
    sample_in = 1'b0;
    unique case (state_q)
      TWS_IDLE: begin
        if (start && enable) begin
          state_d = TWS_SETUP;
          load    = 1'b1;
          left_d  = tx_len_m1;
          rxlen_d = rx_len_m1;
          rd_d    = 1'b0;
        end
      end
      TWS_SETUP, TWS_LOW: begin
        if (tick) begin
          state_d   = TWS_HIGH;
          sample_in = rd_q;
        end
      end
      TWS_HIGH: begin
        if (tick) begin
          if (rd_q && (left_q == '0)) begin
            state_d = TWS_HOLD;
          end else begin
            state_d   = TWS_LOW;
            shift_out = 1'b1;
            if (left_q == '0) begin
              rd_d   = 1'b1;
              left_d = rxlen_q;
            end else begin
              left_d = left_q - 1'b1;
            end
          end
        end
      end
      TWS_HOLD: begin
        if (tick) begin
          state_d = TWS_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = TWS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TWS_IDLE;
      left_q  <= '0;
      rxlen_q <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      rxlen_q <= rxlen_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != TWS_IDLE);
  assign cs_n     = (state_q == TWS_IDLE);
  assign sclk     = (state_q == TWS_HIGH);
  assign drive_en = !rd_q && ((state_q == TWS_SETUP) || (state_q == TWS_HIGH) ||
                              (state_q == TWS_LOW));
  assign done     = done_q;

endmodule

// File: rtl/tw_spi_master.sv
module tw_spi_master #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int PWR_W  = 4,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len_m1,
  input  logic [LEN_W-1:0]  rx_len_m1,
  input  logic [DIV_W-1:0]  div_m1,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo_pull,
  input  logic              sdi_n,
  output logic [PWR_W-1:0]  pwr_en
);

  logic load, shift_out, sample_in, busy, drive_en, tick, tx_msb;

  tw_spi_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start     (start),
    .tx_len_m1 (tx_len_m1),
    .rx_len_m1 (rx_len_m1),
    .tick      (tick),
    .load      (load),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .busy      (busy),
    .drive_en  (drive_en),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .done      (done)
  );

  tw_spi_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .load   (load),
    .div_in (div_m1),
    .tick   (tick)
  );

  tw_spi_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .tx_data   (tx_data),
    .tx_len_m1 (tx_len_m1),
    .sdi_n     (sdi_n),
    .tx_msb    (tx_msb),
    .rx_word   (rx_data)
  );

  // pull low only for a zero command bit; a one is sent by releasing
  assign sdo_pull = drive_en & ~tx_msb;

  for (genvar g = 0; g < PWR_W; g++) begin : g_pwr
    assign pwr_en[g] = enable;
  end

endmodule

// File: rtl/tw_spi_master_chk.sv
module tw_spi_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo_pull,
  input logic done
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !sdo_pull));

  a_r2_pull_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo_pull));

  a_r7_setup_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);

  a_r7_hold_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sclk));

  a_r8_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  a_r8_release_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

endmodule

bind tw_spi_master tw_spi_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .sdo_pull (sdo_pull),
  .done     (done)
);

// File: tb/tw_spi_master_tb.sv
module tw_spi_master_tb;

  logic        clk = 1'b0;
  logic        rst_n, enable, start;
  logic [31:0] tx_data;
  logic [4:0]  tx_len_m1, rx_len_m1;
  logic [7:0]  div_m1;
  logic [31:0] rx_data;
  logic        done, cs_n, sclk, sdo_pull;
  logic [3:0]  pwr_en;
  logic        slave_pull;
  wire         line  = ~(sdo_pull | slave_pull);
  wire         sdi_n = ~line;

  always #4 clk = ~clk;

  tw_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .tx_data(tx_data), .tx_len_m1(tx_len_m1), .rx_len_m1(rx_len_m1),
    .div_m1(div_m1), .rx_data(rx_data), .done(done), .cs_n(cs_n),
    .sclk(sclk), .sdo_pull(sdo_pull), .sdi_n(sdi_n), .pwr_en(pwr_en)
  );

  int n_chk = 0, n_fail = 0;

  // peripheral model and protocol monitor
  int          s_txn, s_rxn, s_rises, s_rd, exp_h, run_len;
  int          frames, dones, setup_cnt, hold_cnt;
  int          v_mode, v_rel, v_run, v_done;
  logic [31:0] s_cmd, s_resp;
  logic        p_sclk, p_cs, p_pull;

  always @(negedge clk) begin
    if (!rst_n) begin
      slave_pull = 1'b0; s_rises = 0; s_rd = 0; run_len = 0;
      p_sclk = 1'b0; p_cs = 1'b1; p_pull = 1'b0;
    end else begin
      if (cs_n) begin
        slave_pull = 1'b0; s_rises = 0; s_rd = 0; run_len = 0;
      end
      if (p_cs && !cs_n) begin
        frames++; s_cmd = '0; setup_cnt = 0; hold_cnt = 0; run_len = 0;
      end
      if (!cs_n) begin
        if (sclk != p_sclk) begin
          if (p_sclk && run_len != exp_h) v_run++;
          if (!p_sclk && s_rises > 0 && run_len != exp_h) v_run++;
          run_len = 1;
        end else begin
          run_len++;
        end
        if (sclk && !p_sclk) begin
          if (s_rises < s_txn) s_cmd = {s_cmd[30:0], line};
          s_rises++;
        end
        if (!sclk && p_sclk && s_rises >= s_txn && s_rd < s_rxn) begin
          slave_pull = ~s_resp[s_rxn-1-s_rd];
          s_rd++;
        end
        if (!sclk && s_rises == 0) setup_cnt++;
        if (!sclk && s_rises == s_txn + s_rxn) hold_cnt++;
        if (sdo_pull && (s_rises > s_txn || (s_rises == s_txn && !sclk))) v_rel++;
      end
      if (sdo_pull != p_pull && sclk) v_mode++;
      if (done && !(cs_n && !p_cs)) v_done++;
      if (cs_n && !p_cs && !done) v_done++;
      if (done) dones++;
      p_sclk = sclk; p_cs = cs_n; p_pull = sdo_pull;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lowmask(input int n);
    return 32'((64'h1 << n) - 64'h1);
  endfunction

  task automatic arm(input logic [31:0] tx, input int tl, input logic [31:0] resp,
                     input int rl, input int dv);
    tx_data = tx; tx_len_m1 = 5'(tl - 1); rx_len_m1 = 5'(rl - 1); div_m1 = 8'(dv);
    s_txn = tl; s_rxn = rl; s_resp = resp; exp_h = dv + 1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic judge(input logic [31:0] tx, input int tl, input logic [31:0] resp,
                       input int rl, input int dv);
    check("R5 rx_data", rx_data, resp & lowmask(rl));
    check("R3 command seen by peripheral", s_cmd, tx & lowmask(tl));
    check("R6 rising edges", 32'(s_rises), 32'(tl + rl));
    check("R7 cs setup clocks", 32'(setup_cnt), 32'(dv + 1));
    check("R7 cs hold clocks", 32'(hold_cnt), 32'(dv + 1));
  endtask

  task automatic do_xfer(input logic [31:0] tx, input int tl, input logic [31:0] resp,
                         input int rl, input int dv);
    int f0 = frames, m0 = v_mode, r0 = v_rel, u0 = v_run, d0 = v_done, n0 = dones;
    bit ok;
    @(negedge clk);
    arm(tx, tl, resp, rl, dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R8 done reached", 32'(ok), 32'd1);
    judge(tx, tl, resp, rl, dv);
    check("R6 single frame", 32'(frames - f0), 32'd1);
    check("R2 pull change with clock high", 32'(v_mode - m0), 32'd0);
    check("R4 pull during response", 32'(v_rel - r0), 32'd0);
    check("R7 half-period length", 32'(v_run - u0), 32'd0);
    repeat (10) @(negedge clk);
    check("R8 rx_data held", rx_data, resp & lowmask(rl));
    check("R8 done pulses", 32'(dones - n0), 32'd1);
    check("R8 done placement", 32'(v_done - d0), 32'd0);
    check("R1 idle cs_n", 32'(cs_n), 32'd1);
  endtask

  task automatic t_reset;
    check("R1 reset cs_n", 32'(cs_n), 32'd1);
    check("R1 reset sclk", 32'(sclk), 32'd0);
    check("R1 reset sdo_pull", 32'(sdo_pull), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R10 pwr_en disabled", 32'(pwr_en), 32'h0);
  endtask

  task automatic t_enable;
    int f0 = frames;
    @(negedge clk);
    arm(32'h5, 4, 32'h3, 4, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check("R9 start ignored when disabled", 32'(frames - f0), 32'd0);
    check("R9 cs_n stays high", 32'(cs_n), 32'd1);
    enable = 1'b1;
    @(negedge clk);
    check("R10 pwr_en enabled", 32'(pwr_en), 32'hF);
  endtask

  task automatic t_busy;
    int f0 = frames;
    bit ok;
    @(negedge clk);
    arm(32'h0000_00C3, 8, 32'h0000_0A5A, 12, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    tx_data = 32'hFFFF_FF3C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R9 done reached", 32'(ok), 32'd1);
    check("R9 command unchanged by busy start", s_cmd, 32'h0000_00C3);
    check("R9 response", rx_data, 32'h0000_0A5A);
    repeat (40) @(negedge clk);
    check("R9 no extra frame", 32'(frames - f0), 32'd1);
  endtask

  task automatic t_back_to_back;
    int f0 = frames;
    bit ok;
    @(negedge clk);
    arm(32'h0000_0019, 5, 32'h0000_0123, 9, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R11 first done", 32'(ok), 32'd1);
    check("R11 first response at done", rx_data, 32'h0000_0123);
    check("R11 first command", s_cmd, 32'h0000_0019);
    arm(32'h0000_2D4B, 14, 32'h0000_0006, 3, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 cs_n low right after done", 32'(cs_n), 32'd0);
    wait_done(ok);
    check("R11 second done", 32'(ok), 32'd1);
    judge(32'h0000_2D4B, 14, 32'h0000_0006, 3, 0);
    check("R11 two frames", 32'(frames - f0), 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    frames = 0; dones = 0; v_mode = 0; v_rel = 0; v_run = 0; v_done = 0;
    setup_cnt = 0; hold_cnt = 0; s_cmd = '0;
    rst_n = 1'b0; enable = 1'b0; start = 1'b0;
    arm(32'h0, 1, 32'h0, 1, 0);
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_enable;
    do_xfer(32'h0000_00A5, 8, 32'h0000_1234, 16, 0);   // R3 R4 R5
    do_xfer(32'h0000_0001, 1, 32'h0000_0000, 1, 3);    // R7 minimum lengths
    do_xfer(32'h0000_0000, 1, 32'h0000_0001, 1, 0);    // R3 zero bit pulls low
    do_xfer(32'hDEAD_BEEF, 32, 32'h0F0F_00FF, 32, 1);  // R3 R5 full width
    do_xfer(32'hFFFF_E5A3, 13, 32'hFFFF_FF5A, 7, 2);   // R3 R5 upper bits dropped
    do_xfer(32'h0000_0000, 6, 32'hFFFF_FFFF, 20, 4);   // R4 R5 all ones response
    t_busy;
    t_back_to_back;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule